// File: doc/BRIEF.md
# Low-Power DDR Power-Up Initialization Sequencer

This block sits on the controller side of a low-power DDR SDRAM. After reset it drives the memory's command, address and bank-address lines through the fixed start-up order the device needs. First it holds a long idle wait, covering the power-up settling time. It then precharges every bank and runs two auto-refresh cycles. Last, it loads the base mode register and then the extended mode register. Between commands it puts only idle (NOP) cycles on the bus. The number of idle cycles after each step is set at elaboration, in clock cycles.

The clock-enable line stays high the whole time. The two register values come in on input buses. The block captures them while reset is held, so it uses the values present when reset is released. When the last wait is over, the block raises `ready` and keeps it high. From then on it issues only NOPs, until the next reset hands the command bus over to the normal traffic logic.

Top module: `lpinit_seq`

## Requirements
- R1: `cke` is 1 in every cycle, including during reset and after the sequence has completed.
- R2: Release `rst_n` and count the first cycle with `rst_n` high as cycle 0. Cycles 0 to PWR_WAIT-1 carry NOP, with {cs_n,ras_n,cas_n,we_n} = 4'b0111, `addr` = 0 and `ba` = 0.
- R3: Cycle PWR_WAIT carries PRECHARGE ALL, encoded as 4'b0010. It has `addr` bit 10 = 1, all other `addr` bits 0, and `ba` = 0.
- R4: After the precharge, exactly T_RP NOP cycles follow before the next command.
- R5: Exactly two AUTO REFRESH commands (4'b0001, `addr` = 0, `ba` = 0) are issued. Each is followed by exactly T_RFC NOP cycles.
- R6: Next comes MODE REGISTER SET (4'b0000) with `ba` = 2'b00 and `addr` = the `mode_val` captured at reset release. Exactly T_MRD NOP cycles follow it.
- R7: Next comes MODE REGISTER SET with `ba` = 2'b10 and `addr` = the `emode_val` captured at reset release. It is followed by exactly T_MRD NOP cycles, and `ready` rises in the cycle after the last of them.
- R8: Once high, `ready` stays high and the bus carries only NOPs until reset. A synchronous active-low reset clears `ready` and restarts the sequence from the power-up wait, from any state.
- R9: Changes on `mode_val` or `emode_val` after reset release have no effect on the values loaded by the two register-set commands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_val | input | ADDR_W | Base mode register value, captured at reset release |
| emode_val | input | ADDR_W | Extended mode register value, captured at reset release |
| cke | output | 1 | Clock enable to the memory, held high |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus |
| ba | output | BA_W | Bank address |
| ready | output | 1 | Initialization complete |

## Verification
Some properties are checked on every cycle:
- the precharge always has address bit 10 set;
- a register-set command only ever selects bank value 00 or 10;
- `ready` never falls outside reset, and no command is issued while it is high;
- the first command after reset comes no earlier than the power-up wait;
- no two commands are closer together than the shortest programmed gap.

Other behaviour only the bench's scenarios can show: the exact command order, the exact NOP count for each particular gap, the register values loaded (including when the inputs change after reset release), and a correct restart when reset arrives partway through the sequence.

// File: rtl/lpinit_pkg.sv
// Shared types for the power-up initialization sequencer.
// Holds the sequence state encoding and the memory command encodings
// as {cs_n, ras_n, cas_n, we_n}.
package lpinit_pkg;

    typedef enum logic [3:0] {
        ST_PWR    = 4'd0,
        ST_PRE    = 4'd1,
        ST_W_RP   = 4'd2,
        ST_REF1   = 4'd3,
        ST_W_RF1  = 4'd4,
        ST_REF2   = 4'd5,
        ST_W_RF2  = 4'd6,
        ST_MRS    = 4'd7,
        ST_W_MR1  = 4'd8,
        ST_EMRS   = 4'd9,
        ST_W_MR2  = 4'd10,
        ST_DONE   = 4'd11
    } seq_state_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } mem_cmd_t;

    localparam mem_cmd_t CMD_NOP  = 4'b0111;
    localparam mem_cmd_t CMD_PRE  = 4'b0010;
    localparam mem_cmd_t CMD_REF  = 4'b0001;
    localparam mem_cmd_t CMD_MRS  = 4'b0000;

endpackage

// File: rtl/lpinit_wait_ctr.sv
// Wait down-counter.
// Loads a start value on request and counts down to zero, then holds.
// Assumes the loader gives (wait length - 1), so a wait state that
// leaves on zero lasts exactly the wait length. Under reset it holds
// RST_VAL, so the power-up wait runs from reset release.
module lpinit_wait_ctr #(
    parameter int CNT_W   = 16,
    parameter int RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    // Reload on request, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(RST_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Flag the end of the current wait.
    assign zero = (cnt_q == '0);

endmodule

// File: rtl/lpinit_fsm.sv
// Sequence controller.
// Steps through: power-up wait, precharge all, two refreshes, base and
// extended register loads, then a terminal ready state. Each one-cycle
// command state loads the wait counter for the gap that follows it.
// Each wait state leaves when the counter reports zero.
// Assumes every wait length is at least 1.
module lpinit_fsm
    import lpinit_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int T_RP  = 3,
    parameter int T_RFC = 8,
    parameter int T_MRD = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wait_zero,
    output seq_state_t       state,
    output logic             ctr_load,
    output logic [CNT_W-1:0] ctr_val
);

    localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] LD_RFC = CNT_W'(T_RFC - 1);
    localparam logic [CNT_W-1:0] LD_MRD = CNT_W'(T_MRD - 1);

    seq_state_t state_q, state_d;

    // State register; reset restarts the power-up wait.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PWR;
        else        state_q <= state_d;
    end

    // Next-state choice: command states last one cycle, waits end on zero.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PWR:   if (wait_zero) state_d = ST_PRE;
            ST_PRE:   state_d = ST_W_RP;
            ST_W_RP:  if (wait_zero) state_d = ST_REF1;
            ST_REF1:  state_d = ST_W_RF1;
            ST_W_RF1: if (wait_zero) state_d = ST_REF2;
            ST_REF2:  state_d = ST_W_RF2;
            ST_W_RF2: if (wait_zero) state_d = ST_MRS;
            ST_MRS:   state_d = ST_W_MR1;
            ST_W_MR1: if (wait_zero) state_d = ST_EMRS;
            ST_EMRS:  state_d = ST_W_MR2;
            ST_W_MR2: if (wait_zero) state_d = ST_DONE;
            ST_DONE:  state_d = ST_DONE;
            default:  state_d = ST_PWR;
        endcase
    end

    // Counter reload: each command state arms the gap that follows it.
    always_comb begin
        ctr_load = 1'b0;
        ctr_val  = '0;
        unique case (state_q)
            ST_PRE:            begin ctr_load = 1'b1; ctr_val = LD_RP;  end
            ST_REF1, ST_REF2:  begin ctr_load = 1'b1; ctr_val = LD_RFC; end
            ST_MRS, ST_EMRS:   begin ctr_load = 1'b1; ctr_val = LD_MRD; end
            default:           begin ctr_load = 1'b0; ctr_val = '0;     end
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/lpinit_cmd_enc.sv
// Command bus encoder.
// Maps the sequence state to the memory command, address and bank
// lines, plus the ready flag. It is combinational on the registered
// state, so outputs change only after a clock edge. Assumes
// ADDR_W >= 11, so the all-banks bit (bit 10) exists.
module lpinit_cmd_enc
    import lpinit_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2
) (
    input  seq_state_t        state,
    input  logic [ADDR_W-1:0] mode_q,
    input  logic [ADDR_W-1:0] emode_q,
    output mem_cmd_t          cmd,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic              ready
);

    localparam int                AP_BIT  = 10;
    localparam logic [BA_W-1:0]   BA_BASE = BA_W'(0);
    localparam logic [BA_W-1:0]   BA_EXT  = BA_W'(2);

    // Command, address and bank selection for each state.
    always_comb begin
        cmd  = CMD_NOP;
        addr = '0;
        ba   = BA_BASE;
        unique case (state)
            ST_PRE: begin
                cmd          = CMD_PRE;
                addr[AP_BIT] = 1'b1;
            end
            ST_REF1, ST_REF2: cmd = CMD_REF;
            ST_MRS: begin
                cmd  = CMD_MRS;
                addr = mode_q;
            end
            ST_EMRS: begin
                cmd  = CMD_MRS;
                addr = emode_q;
                ba   = BA_EXT;
            end
            default: begin
                cmd  = CMD_NOP;
                addr = '0;
                ba   = BA_BASE;
            end
        endcase
    end

    // Ready once the terminal state is reached.
    assign ready = (state == ST_DONE);

endmodule

// File: rtl/lpinit_seq.sv
// Top of the power-up initialization sequencer.
// Captures the two register values while reset is held, runs the
// controller with its wait counter, and drives the memory command pins.
// Assumes every wait parameter is at least 1 and ADDR_W >= 11.
module lpinit_seq
    import lpinit_pkg::*;
#(
    parameter int ADDR_W   = 13,
    parameter int BA_W     = 2,
    parameter int PWR_WAIT = 20000,
    parameter int T_RP     = 3,
    parameter int T_RFC    = 8,
    parameter int T_MRD    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] mode_val,
    input  logic [ADDR_W-1:0] emode_val,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic              ready
);

    localparam int MAX_A    = (T_RP > T_RFC) ? T_RP : T_RFC;
    localparam int MAX_B    = (MAX_A > T_MRD) ? MAX_A : T_MRD;
    localparam int MAX_WAIT = (MAX_B > PWR_WAIT) ? MAX_B : PWR_WAIT;
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);

    logic [ADDR_W-1:0] mode_q, emode_q;
    seq_state_t        state;
    logic              ctr_load, wait_zero;
    logic [CNT_W-1:0]  ctr_val;
    mem_cmd_t          cmd;

    // Track the register inputs during reset; freeze them once released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= mode_val;
            emode_q <= emode_val;
        end
    end

    lpinit_wait_ctr #(
        .CNT_W   (CNT_W),
        .RST_VAL (PWR_WAIT - 1)
    ) ctr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctr_load),
        .load_val (ctr_val),
        .zero     (wait_zero)
    );

    lpinit_fsm #(
        .CNT_W (CNT_W),
        .T_RP  (T_RP),
        .T_RFC (T_RFC),
        .T_MRD (T_MRD)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wait_zero (wait_zero),
        .state     (state),
        .ctr_load  (ctr_load),
        .ctr_val   (ctr_val)
    );

    lpinit_cmd_enc #(
        .ADDR_W (ADDR_W),
        .BA_W   (BA_W)
    ) enc_i (
        .state   (state),
        .mode_q  (mode_q),
        .emode_q (emode_q),
        .cmd     (cmd),
        .addr    (addr),
        .ba      (ba),
        .ready   (ready)
    );

    // Clock enable is never dropped during or after initialization.
    assign cke   = 1'b1;
    assign cs_n  = cmd.cs_n;
    assign ras_n = cmd.ras_n;
    assign cas_n = cmd.cas_n;
    assign we_n  = cmd.we_n;

endmodule

// File: rtl/lpinit_seq_chk.sv
// Checker for the initialization sequencer, bound to the top.
// Watches the command pins only: command spacing, precharge and
// register-set fields, and the stickiness of ready.
module lpinit_seq_chk #(
    parameter int ADDR_W   = 13,
    parameter int BA_W     = 2,
    parameter int PWR_WAIT = 20000,
    parameter int T_RP     = 3,
    parameter int T_RFC    = 8,
    parameter int T_MRD    = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic [BA_W-1:0]   ba,
    input logic              ready
);

    localparam int MIN_A   = (T_RP < T_RFC) ? T_RP : T_RFC;
    localparam int MIN_GAP = (MIN_A < T_MRD) ? MIN_A : T_MRD;

    logic [3:0]  cmd_w;
    logic        is_cmd;
    logic [31:0] gap_q;
    logic        seen_q;

    assign cmd_w  = {cs_n, ras_n, cas_n, we_n};
    assign is_cmd = (cmd_w != 4'b0111);

    // Count idle cycles since reset or the last command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (is_cmd) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != 32'hFFFF_FFFF) begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    AST_FIRST_CMD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && !seen_q) |-> (gap_q >= 32'(PWR_WAIT))); // R2

    AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w == 4'b0010) |-> addr[10]); // R3

    AST_CMD_MIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && seen_q) |-> (gap_q >= 32'(MIN_GAP))); // R4

    AST_MRS_BANK_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w == 4'b0000) |-> (ba == BA_W'(0) || ba == BA_W'(2))); // R6

    AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready); // R8

    AST_READY_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !is_cmd); // R8

endmodule

bind lpinit_seq lpinit_seq_chk #(
    .ADDR_W   (ADDR_W),
    .BA_W     (BA_W),
    .PWR_WAIT (PWR_WAIT),
    .T_RP     (T_RP),
    .T_RFC    (T_RFC),
    .T_MRD    (T_MRD)
) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .addr  (addr),
    .ba    (ba),
    .ready (ready)
);

// File: tb/lpinit_seq_tb_top.sv
// Bench for the initialization sequencer: random register values,
// random reset points and directed full runs, checked cycle by cycle
// against a schedule computed from the requirements.
module lpinit_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 13;
    localparam int BA_W       = 2;
    localparam int PW         = 20;
    localparam int RP         = 3;
    localparam int RFC        = 7;
    localparam int MRD        = 2;
    localparam int I_PRE      = PW;
    localparam int I_REF1     = I_PRE + 1 + RP;
    localparam int I_REF2     = I_REF1 + 1 + RFC;
    localparam int I_MRS      = I_REF2 + 1 + RFC;
    localparam int I_EMRS     = I_MRS + 1 + MRD;
    localparam int I_DONE     = I_EMRS + 1 + MRD;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] mode_val = '0;
    logic [ADDR_W-1:0] emode_val = '0;
    logic              cke, cs_n, ras_n, cas_n, we_n, ready;
    logic [ADDR_W-1:0] addr;
    logic [BA_W-1:0]   ba;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lpinit_seq #(
        .ADDR_W (ADDR_W), .BA_W (BA_W), .PWR_WAIT (PW),
        .T_RP (RP), .T_RFC (RFC), .T_MRD (MRD)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .mode_val (mode_val), .emode_val (emode_val),
        .cke (cke), .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
        .addr (addr), .ba (ba), .ready (ready)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected command {cs,ras,cas,we} at cycle idx after reset release.
    function automatic logic [3:0] exp_cmd(int idx);
        if (idx == I_PRE) return 4'b0010;
        if (idx == I_REF1 || idx == I_REF2) return 4'b0001;
        if (idx == I_MRS || idx == I_EMRS) return 4'b0000;
        return 4'b0111;
    endfunction

    function automatic logic [ADDR_W-1:0] exp_addr(int idx, logic [ADDR_W-1:0] m,
                                                   logic [ADDR_W-1:0] e);
        if (idx == I_PRE) return ADDR_W'(1 << 10);
        if (idx == I_MRS) return m;
        if (idx == I_EMRS) return e;
        return '0;
    endfunction

    function automatic string tag_of(int idx, bit changed);
        if (changed && (idx == I_MRS || idx == I_EMRS)) return "R9";
        if (idx < I_PRE) return "R2";
        if (idx == I_PRE) return "R3";
        if (idx < I_REF1) return "R4";
        if (idx < I_MRS) return "R5";
        if (idx < I_EMRS) return "R6";
        if (idx <= I_DONE) return "R7";
        return "R8";
    endfunction

    // One run: reset, release, then n_cyc cycles checked against the schedule.
    task automatic run_seq(int n_cyc, int rst_len, bit change_inputs,
                           logic [ADDR_W-1:0] m, logic [ADDR_W-1:0] e);
        logic [ADDR_W-1:0] cap_m, cap_e;
        string t;
        @(negedge clk);
        rst_n     = 1'b0;
        mode_val  = m;
        emode_val = e;
        for (int k = 0; k < rst_len; k++) @(negedge clk);
        chk("R8", "ready in reset", 32'(ready), 32'd0);
        chk("R8", "cmd in reset", 32'({cs_n, ras_n, cas_n, we_n}), 32'h7);
        chk("R1", "cke in reset", 32'(cke), 32'd1);
        cap_m = mode_val;
        cap_e = emode_val;
        rst_n = 1'b1;
        for (int idx = 0; idx < n_cyc; idx++) begin
            if (idx > 0) @(negedge clk);
            t = tag_of(idx, change_inputs);
            chk(t, "cmd", 32'({cs_n, ras_n, cas_n, we_n}), 32'(exp_cmd(idx)));
            chk(t, "addr", 32'(addr), 32'(exp_addr(idx, cap_m, cap_e)));
            chk(t, "ba", 32'(ba), (idx == I_EMRS) ? 32'd2 : 32'd0);
            chk((idx >= I_DONE) ? "R8" : "R7", "ready", 32'(ready),
                (idx >= I_DONE) ? 32'd1 : 32'd0);
            chk("R1", "cke", 32'(cke), 32'd1);
            if (change_inputs) begin
                mode_val  = ADDR_W'($urandom);
                emode_val = ADDR_W'($urandom);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        // Directed: full runs with extreme register values.
        run_seq(I_DONE + 6, 2, 1'b0, '1, '0);
        run_seq(I_DONE + 3, 1, 1'b0, ADDR_W'(13'h0155), ADDR_W'(13'h1AAA));
        // Directed: reset right at the precharge and in the ready state (R8).
        run_seq(I_PRE + 1, 1, 1'b0, ADDR_W'(3), ADDR_W'(5));
        run_seq(I_DONE + 2, 3, 1'b0, ADDR_W'(7), ADDR_W'(9));
        // Directed: inputs change after release (R9).
        run_seq(I_DONE + 2, 2, 1'b1, ADDR_W'(13'h0033), ADDR_W'(13'h0040));
        // Random runs with random cut points and reset lengths.
        for (int r = 0; r < 25; r++) begin
            run_seq(5 + int'($urandom_range(I_DONE + 8)), 1 + int'($urandom_range(3)),
                    1'($urandom), ADDR_W'($urandom), ADDR_W'($urandom));
        end
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done_flag) begin
            done_flag = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule